// File: doc/BRIEF.md
# Table-Corrected Data-Window Recovery Loop

This block regenerates a read-data window from a raw pulse stream coming off a disk head. A 4-bit counter advances once per cycle of the local clock. Each rising edge of the incoming data pulse samples the count. When the sample is zero the loop is taken to be in step, and counting goes on as usual. Any other sample makes the next counter step come from a correction table, so the count slips back or jumps ahead by one or two positions. The slip is larger the further the sample sits from zero.

A toggle flip-flop flips each time the counter passes its top and comes round to its low half. This gives a window signal at one thirty-second of the clock rate whose phase follows the data. A free-run input turns the loop into a plain divide-by-16 for use while no data is present. The raw pulse is asynchronous and passes through a two-stage synchroniser before edge detection. Decoding of data bits from the window is left to the logic downstream.

Top module: `disk_window_pll`

## Requirements
- R1: While `rst` is 1 at a clock edge, `count` and `window` both become 0 at that edge.
- R2: With no detected pulse edge (or with `free_run` at 1), `count` advances by 1 modulo 16 on every clock edge, so 15 is followed by 0.
- R3: On the step that follows a detected pulse edge with `free_run` at 0, the next count depends on the current count c. For c = 1, 2, 3 it is c; for c = 4..7 it is c-1; for c = 8..12 it is c+3; for c = 13, 14, 15 it is c+2 modulo 16.
- R4: A detected edge while `count` is 0 gives the ordinary next value 1.
- R5: A pulse that rises between two clock edges is seen through two synchronising flip-flops. The correction it causes is applied at the third rising clock edge after the rise, using the count held just before that edge.
- R6: A pulse held high for many cycles causes exactly one correction. Another correction needs the pulse to go low and then rise again.
- R7: While `free_run` is 1, pulse edges have no effect on `count` or `window`.
- R8: `window` toggles on exactly those clock edges where `count` moves from a value of 8 or more to a value below 8. In free run it therefore has a period of 32 clocks.
- R9: When a correction and a wrap fall on the same step, the table value wins. At count 15 the next count is 1 and `window` toggles. At count 14 the next count is 0 and `window` toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous active-high reset |
| data_pulse | input | 1 | Raw asynchronous data pulse from the drive |
| free_run | input | 1 | 1 = plain divide-by-16, pulse edges ignored |
| window | output | 1 | Recovered data window, clock divided by 32 |
| count | output | 4 | Current phase counter value |

## Verification
A wrong table entry or a mis-timed edge shows at `count` on the very next clock. After that the count stays offset, and `window` flips earlier or later than it should. A counter that is left running with a wrong offset therefore moves every later window edge by the same amount. Because of this, the bench compares both outputs with a cycle-exact reference on every clock. A synchroniser depth that is off by one shows as a correction applied one step early or late. Edge detection that fires again on a held pulse shows as a second jump a few cycles after the first.

// File: rtl/dwpll_pkg.sv
package dwpll_pkg;
    localparam int CNT_W   = 4;
    localparam int CNT_MOD = 1 << CNT_W;
    localparam int SYNC_N  = 2;

    typedef logic [CNT_W-1:0] count_t;

    typedef struct packed {
        count_t nxt;
        logic   wrap;
    } step_t;

    // Correction-half table: next count after a detected pulse edge.
    function automatic count_t corr_next(input count_t c);
        count_t r;
        case (c)
            4'h0: r = 4'h1;
            4'h1: r = 4'h1;
            4'h2: r = 4'h2;
            4'h3: r = 4'h3;
            4'h4: r = 4'h3;
            4'h5: r = 4'h4;
            4'h6: r = 4'h5;
            4'h7: r = 4'h6;
            4'h8: r = 4'hB;
            4'h9: r = 4'hC;
            4'hA: r = 4'hD;
            4'hB: r = 4'hE;
            4'hC: r = 4'hF;
            4'hD: r = 4'hF;
            4'hE: r = 4'h0;
            default: r = 4'h1;
        endcase
        return r;
    endfunction

    // Passing from the upper half of the range into the lower half is a wrap.
    function automatic logic is_wrap(input count_t cur, input count_t nxt);
        return cur[CNT_W-1] & ~nxt[CNT_W-1];
    endfunction
endpackage

// File: rtl/dwpll_edge_sync.sv
module dwpll_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] pipe;
    logic              last;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[0] <= 1'b0;
                    else     pipe[0] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) pipe[i] <= 1'b0;
                    else     pipe[i] <= pipe[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= pipe[STAGES-1];
    end

    assign rise = pipe[STAGES-1] & ~last;
endmodule

// File: rtl/dwpll_step.sv
module dwpll_step
    import dwpll_pkg::*;
(
    input  count_t cur,
    input  logic   correct,
    output step_t  step
);
    always_comb begin
        if (correct) step.nxt = corr_next(cur);
        else         step.nxt = cur + count_t'(1);
        step.wrap = is_wrap(cur, step.nxt);
    end
endmodule

// File: rtl/dwpll_counter.sv
module dwpll_counter
    import dwpll_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pulse_edge,
    input  logic   free_run,
    output count_t count,
    output logic   window
);
    step_t step;
    logic  apply;

    assign apply = pulse_edge & ~free_run;

    dwpll_step u_step (
        .cur     (count),
        .correct (apply),
        .step    (step)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            window <= 1'b0;
        end else begin
            count <= step.nxt;
            if (step.wrap) window <= ~window;
        end
    end
endmodule

// File: rtl/disk_window_pll.sv
module disk_window_pll
    import dwpll_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             data_pulse,
    input  logic             free_run,
    output logic             window,
    output logic [CNT_W-1:0] count
);
    logic pulse_edge;

    dwpll_edge_sync #(.STAGES(SYNC_N)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (data_pulse),
        .rise     (pulse_edge)
    );

    dwpll_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .pulse_edge (pulse_edge),
        .free_run   (free_run),
        .count      (count),
        .window     (window)
    );
endmodule

// File: rtl/disk_window_pll_chk.sv
module disk_window_pll_chk (
    input logic       clk,
    input logic       rst,
    input logic       free_run,
    input logic       pulse_edge,
    input logic [3:0] count,
    input logic       window
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (count == 4'h0 && !window));

    p_plain_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!pulse_edge || free_run) |=> count == $past(count) + 4'd1);

    p_jump_r3: assert property (@(posedge clk) disable iff (rst)
        (pulse_edge && !free_run && count != 4'h0) |=> count != $past(count) + 4'd1);

    p_in_sync_r4: assert property (@(posedge clk) disable iff (rst)
        (pulse_edge && !free_run && count == 4'h0) |=> count == 4'h1);

    p_single_edge_r6: assert property (@(posedge clk) disable iff (rst)
        pulse_edge |=> !pulse_edge);

    p_window_toggle_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((window != $past(window)) == ($past(count[3]) && !count[3])));

    p_wrap_corr_r9: assert property (@(posedge clk) disable iff (rst)
        (pulse_edge && !free_run && count == 4'hF) |=> (count == 4'h1 && window != $past(window)));
endmodule

bind disk_window_pll disk_window_pll_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .free_run   (free_run),
    .pulse_edge (pulse_edge),
    .count      (count),
    .window     (window)
);

// File: tb/disk_window_pll_tb.sv
module disk_window_pll_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       data_pulse = 1'b0;
    logic       free_run = 1'b0;
    logic       window;
    logic [3:0] count;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    // reference state
    logic [3:0] m_cnt = 4'h0;
    logic       m_win = 1'b0;
    logic       m_s1 = 1'b0, m_s2 = 1'b0, m_s3 = 1'b0;

    always #10 clk = ~clk;

    disk_window_pll dut_i (
        .clk        (clk),
        .rst        (rst),
        .data_pulse (data_pulse),
        .free_run   (free_run),
        .window     (window),
        .count      (count)
    );

    // Expected corrected value, from the graded offsets relative to c+1.
    function automatic logic [3:0] corr_exp(input logic [3:0] c);
        int d;
        if (c == 0)       d = 0;
        else if (c <= 3)  d = -1;
        else if (c <= 7)  d = -2;
        else if (c <= 12) d = 2;
        else              d = 1;
        return 4'((int'(c) + 1 + d + 16) % 16);
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_advance(input logic d, input logic f);
        logic       e;
        logic [3:0] n;
        e = m_s2 & ~m_s3;
        n = (e && !f) ? corr_exp(m_cnt) : m_cnt + 4'd1;
        if (m_cnt[3] && !n[3]) m_win = ~m_win;
        m_cnt = n;
        m_s3 = m_s2;
        m_s2 = m_s1;
        m_s1 = d;
    endtask

    task automatic cycle(input logic d, input logic f);
        @(negedge clk);
        chk(count == m_cnt, {cur_req, " count"}, count, m_cnt);
        chk(window == m_win, {cur_req, " window"}, window, m_win);
        data_pulse = d;
        free_run = f;
        model_advance(d, f);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        data_pulse = 1'b0;
        repeat (3) @(negedge clk);
        chk(count == 4'h0, "R1 reset count", count, 0);
        chk(window == 1'b0, "R1 reset window", window, 0);
        m_cnt = 4'h0; m_win = 1'b0; m_s1 = 1'b0; m_s2 = 1'b0; m_s3 = 1'b0;
        rst = 1'b0;
        model_advance(data_pulse, free_run);
    endtask

    // Aim one pulse so the correction lands on count c.
    task automatic aim(input logic [3:0] c, input int hold);
        repeat (4) cycle(1'b0, 1'b0);
        while (m_cnt != 4'(c - 4'd2)) cycle(1'b0, 1'b0);
        repeat (hold) cycle(1'b1, 1'b0);
        repeat (3) cycle(1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic d;
        logic f;
        void'($urandom(32'd20240611));
        free_run = 1'b0;
        do_reset();

        // Free run: plain divide-by-16, edges ignored.
        cur_req = "R7";
        for (int i = 0; i < 80; i++) cycle(i[2], 1'b1);
        cur_req = "R2";
        for (int i = 0; i < 40; i++) cycle(1'b0, 1'b0);
        cur_req = "R8";
        for (int i = 0; i < 64; i++) cycle(1'b0, 1'b1);

        // Every table entry, single-cycle pulses.
        for (int c = 0; c < 16; c++) begin
            if (c == 0)       cur_req = "R4";
            else if (c == 8)  cur_req = "R5";
            else if (c >= 14) cur_req = "R9";
            else              cur_req = "R3";
            aim(4'(c), 1);
        end

        // Held-high pulses give one correction each.
        cur_req = "R6";
        aim(4'h5, 12);
        aim(4'hA, 20);

        // Random mix.
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            if (i % 250 == 0) f = ($urandom % 3) == 0;
            d = ($urandom % 4) == 0;
            cur_req = f ? "R7" : "R3";
            cycle(d, f);
        end

        do_reset();
        cur_req = "R2";
        repeat (20) cycle(1'b0, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule